// File: doc/BRIEF.md
# Accumulator Core Execute Stage

This block is the execute stage of a small 8-bit accumulator machine. Each instruction cycle it takes one 12-bit word and decodes it into one of a fixed set of operations. The set covers bitwise logic, add and subtract, increment and decrement, rotate through carry, nibble swap and clear. The block reads one operand from a 32-entry file register bank. The address comes from the low five bits of the word, and literal forms take an 8-bit constant from the word instead. The result is written back to the working register W or to the addressed file register. The block then updates the flag group that belongs to that operation.

The block also holds the carry, digit-carry, zero, time-out and power-down bits. When a counting test reaches zero, the block stalls the next instruction slot and discards the word presented there. A rate input picks one clock per instruction cycle (fast) or four clocks (compatible). A configuration input decides whether add and subtract fold in the carry. A word outside the supported set changes nothing and raises an error output for that instruction cycle.

Top module: `exu_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, W, C, DC, Z, the time-out and power-down bits, `skip_req`, `illegal` and `wdt_clr` all read 0.
- R2: For register-operand words 0001 oodfffff, bit 5 (d) picks the target: 1 writes file register fffff and leaves W unchanged, 0 writes W. Literal words 1110/1101/1111 kkkkkkkk always write W. `res_to_file` reports which target was written.
- R3: AND (0001 01d, literal 1110), OR (0001 00d, literal 1101), XOR (0001 10d, literal 1111) and NOT (0010 011, operand XOR FFh) produce the bitwise result and change Z only.
- R4: ADD (0001 11d) sums W and the operand. When `carry_ignore` is 0 it also adds C. It sets C to the carry out of bit 7, DC to the carry out of bit 3, and Z when the 8-bit result is 0.
- R5: SUB (0000 101, file minus W, written to the file) subtracts W. When `carry_ignore` is 0 it also subtracts the inverse of C. C=1 means no borrow out of bit 7 and DC=1 means no borrow out of bit 3. Z is set on a zero result.
- R6: INC (0010 101), DEC (0000 111), file clear (0000 011) and the W clear word 0000 0100 0000 write the operand plus one, minus one, or zero, and change Z only.
- R7: RL (0011 011) and RR (0011 001) rotate the 9-bit value {C, operand} one place left or right. They change C only.
- R8: SWAP (0011 101) exchanges the two nibbles of the operand and changes no flag.
- R9: INCSZ (0011 111) and DECSZ (0010 111) write their result and change no flag. A zero result raises `skip_req` for the next instruction cycle. The word presented in that cycle is discarded, and `skip_req` drops when that cycle ends.
- R10: The word 0000 0000 0100 sets the time-out and power-down bits to 1, pulses `wdt_clr` for one clock, and leaves W unchanged.
- R11: Any word outside the set above leaves W, the file bank and all flags unchanged, and raises `illegal` for that one instruction cycle.
- R12: With `turbo` at 1, an instruction executes on every clock. With `turbo` at 0, it executes on every fourth clock after reset. `cyc_end` is high for the clock following each execute edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| turbo | input | 1 | 1: one clock per instruction cycle, 0: four clocks |
| carry_ignore | input | 1 | 1: add and subtract leave the carry out of the sum |
| insn | input | 12 | Instruction word, sampled on the execute edge |
| w_out | output | 8 | Working register W |
| res_out | output | 8 | Result of the latest executed operation |
| res_to_file | output | 1 | Latest result went to the file bank (1) or W (0) |
| st_c | output | 1 | Carry / no-borrow flag |
| st_dc | output | 1 | Digit carry flag |
| st_z | output | 1 | Zero flag |
| st_to | output | 1 | Time-out bit |
| st_pd | output | 1 | Power-down bit |
| skip_req | output | 1 | Next instruction slot is being skipped |
| illegal | output | 1 | Word of the latest cycle was not recognised |
| wdt_clr | output | 1 | One-clock watchdog clear strobe |
| cyc_end | output | 1 | An instruction cycle ended on the last edge |

## Verification
Every result, flag and strobe is registered on the execute edge. It becomes visible in the clock that follows, which is the clock in which `cyc_end` is high. The bench changes `insn` only on a falling edge, then waits for the first falling edge at which `cyc_end` reads 1, and samples all outputs there. That is one clock later in fast mode and four in compatible mode. A skipped slot is handled the same way: its discard shows one whole instruction cycle after the counting test, and the bench checks for it there. File register contents are read back through an OR into a cleared W.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XW = 8;
  localparam int RA = 5;
  localparam int IW = 12;
  localparam int HW = XW / 2;

  typedef enum logic [4:0] {
    OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ADD, OP_SUB, OP_CLR, OP_INC, OP_DEC,
    OP_INCSZ, OP_DECSZ, OP_RL, OP_RR, OP_SWAP, OP_CLRW, OP_WDT, OP_BAD
  } op_e;

  typedef struct packed {
    op_e           op;
    logic          use_lit;
    logic          wr_w;
    logic          wr_f;
    logic          upd_z;
    logic          skz;
    logic [XW-1:0] lit;
    logic [RA-1:0] addr;
  } dec_t;
endpackage

// File: rtl/exu_timing.sv
module exu_timing #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic turbo,
  output logic strobe,
  output logic cyc_end_q
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] ph;

  assign strobe = turbo | (ph == LAST);

  always_ff @(posedge clk) begin
    if (rst || turbo) ph <= '0;
    else if (ph == LAST) ph <= '0;
    else ph <= ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cyc_end_q <= 1'b0;
    else cyc_end_q <= strobe;
  end
endmodule

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          d
);
  always_comb begin
    d         = '0;
    d.op      = OP_BAD;
    d.addr    = word[RA-1:0];
    d.lit     = word[XW-1:0];
    casez (word)
      12'b1110_????_????: begin d.op = OP_AND; d.use_lit = 1'b1; d.wr_w = 1'b1; d.upd_z = 1'b1; end
      12'b1101_????_????: begin d.op = OP_OR;  d.use_lit = 1'b1; d.wr_w = 1'b1; d.upd_z = 1'b1; end
      12'b1111_????_????: begin d.op = OP_XOR; d.use_lit = 1'b1; d.wr_w = 1'b1; d.upd_z = 1'b1; end
      12'b0000_0100_0000: begin d.op = OP_CLRW; d.wr_w = 1'b1; d.upd_z = 1'b1; end
      12'b0000_0000_0100: begin d.op = OP_WDT; end
      12'b0001_00??_????: begin d.op = OP_OR;  d.wr_f = word[5]; d.wr_w = ~word[5]; d.upd_z = 1'b1; end
      12'b0001_01??_????: begin d.op = OP_AND; d.wr_f = word[5]; d.wr_w = ~word[5]; d.upd_z = 1'b1; end
      12'b0001_10??_????: begin d.op = OP_XOR; d.wr_f = word[5]; d.wr_w = ~word[5]; d.upd_z = 1'b1; end
      12'b0001_11??_????: begin d.op = OP_ADD; d.wr_f = word[5]; d.wr_w = ~word[5]; d.upd_z = 1'b1; end
      12'b0000_101?_????: begin d.op = OP_SUB;   d.wr_f = 1'b1; d.upd_z = 1'b1; end
      12'b0000_011?_????: begin d.op = OP_CLR;   d.wr_f = 1'b1; d.upd_z = 1'b1; end
      12'b0000_111?_????: begin d.op = OP_DEC;   d.wr_f = 1'b1; d.upd_z = 1'b1; end
      12'b0010_011?_????: begin d.op = OP_NOT;   d.wr_f = 1'b1; d.upd_z = 1'b1; end
      12'b0010_101?_????: begin d.op = OP_INC;   d.wr_f = 1'b1; d.upd_z = 1'b1; end
      12'b0010_111?_????: begin d.op = OP_DECSZ; d.wr_f = 1'b1; d.skz = 1'b1; end
      12'b0011_001?_????: begin d.op = OP_RR;    d.wr_f = 1'b1; end
      12'b0011_011?_????: begin d.op = OP_RL;    d.wr_f = 1'b1; end
      12'b0011_101?_????: begin d.op = OP_SWAP;  d.wr_f = 1'b1; end
      12'b0011_111?_????: begin d.op = OP_INCSZ; d.wr_f = 1'b1; d.skz = 1'b1; end
      default:            d.op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  op_e           op,
  input  logic          use_lit,
  input  logic          upd_z,
  input  logic          skz,
  input  logic [XW-1:0] lit,
  input  logic [XW-1:0] fval,
  input  logic [XW-1:0] w,
  input  logic          carry_ignore,
  input  logic          c_i,
  input  logic          dc_i,
  input  logic          z_i,
  output logic [XW-1:0] res,
  output logic          c_n,
  output logic          dc_n,
  output logic          z_n,
  output logic          zero_skip
);
  localparam logic [XW-1:0] ONE = XW'(1);

  logic [XW-1:0] opnd;
  logic [XW:0]   s9;
  logic [HW:0]   s5;
  logic          cb;
  logic [XW-1:0] addend;

  assign opnd = use_lit ? lit : fval;

  always_comb begin
    res    = opnd;
    c_n    = c_i;
    dc_n   = dc_i;
    z_n    = z_i;
    cb     = 1'b0;
    addend = w;
    s9     = '0;
    s5     = '0;
    case (op)
      OP_AND:  res = opnd & w;
      OP_OR:   res = opnd | w;
      OP_XOR:  res = opnd ^ w;
      OP_NOT:  res = opnd ^ {XW{1'b1}};
      OP_ADD, OP_SUB: begin
        if (op == OP_ADD) begin
          cb     = carry_ignore ? 1'b0 : c_i;
          addend = w;
        end else begin
          cb     = carry_ignore ? 1'b1 : c_i;
          addend = ~w;
        end
        s9   = {1'b0, opnd} + {1'b0, addend} + {{XW{1'b0}}, cb};
        s5   = {1'b0, opnd[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cb};
        res  = s9[XW-1:0];
        c_n  = s9[XW];
        dc_n = s5[HW];
      end
      OP_CLR, OP_CLRW:   res = '0;
      OP_INC, OP_INCSZ:  res = opnd + ONE;
      OP_DEC, OP_DECSZ:  res = opnd - ONE;
      OP_RL: begin
        res = {opnd[XW-2:0], c_i};
        c_n = opnd[XW-1];
      end
      OP_RR: begin
        res = {c_i, opnd[XW-1:1]};
        c_n = opnd[0];
      end
      OP_SWAP: res = {opnd[HW-1:0], opnd[XW-1:HW]};
      default: res = opnd;
    endcase
    if (upd_z) z_n = (res == '0);
    zero_skip = skz && (res == '0);
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          turbo,
  input  logic          carry_ignore,
  input  logic [IW-1:0] insn,
  output logic [XW-1:0] w_out,
  output logic [XW-1:0] res_out,
  output logic          res_to_file,
  output logic          st_c,
  output logic          st_dc,
  output logic          st_z,
  output logic          st_to,
  output logic          st_pd,
  output logic          skip_req,
  output logic          illegal,
  output logic          wdt_clr,
  output logic          cyc_end
);
  logic          stb;
  dec_t          dec;
  logic [XW-1:0] fval;
  logic [XW-1:0] res;
  logic          c_n, dc_n, z_n, zskip;
  logic          live;
  logic          f_we;

  logic [XW-1:0] w_q, res_q;
  logic          rf_q, c_q, dc_q, z_q, to_q, pd_q, stall_q, bad_q, wdt_q;

  exu_timing #(.PHASES(PHASES)) u_tim (
    .clk(clk), .rst(rst), .turbo(turbo), .strobe(stb), .cyc_end_q(cyc_end)
  );

  exu_decode u_dec (.word(insn), .d(dec));

  assign live = stb && !stall_q && !rst;
  assign f_we = live && dec.wr_f;

  exu_regfile #(.DW(XW), .AW(RA)) u_rf (
    .clk(clk), .we(f_we), .addr(dec.addr), .wdata(res), .rdata(fval)
  );

  exu_alu u_alu (
    .op(dec.op), .use_lit(dec.use_lit), .upd_z(dec.upd_z), .skz(dec.skz),
    .lit(dec.lit), .fval(fval), .w(w_q), .carry_ignore(carry_ignore),
    .c_i(c_q), .dc_i(dc_q), .z_i(z_q),
    .res(res), .c_n(c_n), .dc_n(dc_n), .z_n(z_n), .zero_skip(zskip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q     <= '0;
      res_q   <= '0;
      rf_q    <= 1'b0;
      c_q     <= 1'b0;
      dc_q    <= 1'b0;
      z_q     <= 1'b0;
      to_q    <= 1'b0;
      pd_q    <= 1'b0;
      stall_q <= 1'b0;
      bad_q   <= 1'b0;
      wdt_q   <= 1'b0;
    end else begin
      wdt_q <= 1'b0;
      if (stb) begin
        stall_q <= 1'b0;
        bad_q   <= 1'b0;
        if (!stall_q) begin
          if (dec.op == OP_BAD) begin
            bad_q <= 1'b1;
          end else if (dec.op == OP_WDT) begin
            to_q  <= 1'b1;
            pd_q  <= 1'b1;
            wdt_q <= 1'b1;
          end else begin
            res_q   <= res;
            rf_q    <= dec.wr_f;
            c_q     <= c_n;
            dc_q    <= dc_n;
            z_q     <= z_n;
            stall_q <= zskip;
            if (dec.wr_w) w_q <= res;
          end
        end
      end
    end
  end

  assign w_out       = w_q;
  assign res_out     = res_q;
  assign res_to_file = rf_q;
  assign st_c        = c_q;
  assign st_dc       = dc_q;
  assign st_z        = z_q;
  assign st_to       = to_q;
  assign st_pd       = pd_q;
  assign skip_req    = stall_q;
  assign illegal     = bad_q;
  assign wdt_clr     = wdt_q;
endmodule

// File: rtl/exu_chk.sv
module exu_chk (
  input logic       clk,
  input logic       rst,
  input logic       turbo,
  input logic       cyc_end,
  input logic       skip_req,
  input logic       illegal,
  input logic       wdt_clr,
  input logic       to,
  input logic       pd,
  input logic [7:0] w,
  input logic [2:0] fl
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (w == 8'h00 && fl == 3'b000 && !to && !pd && !skip_req && !illegal && !wdt_clr))
    else $error("p_reset_clear_r1");

  p_skip_discard_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && $past(skip_req)) |-> ($stable(w) && $stable(fl) && !skip_req && !illegal))
    else $error("p_skip_discard_r9");

  p_wdt_sets_bits_r10: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |-> (to && pd))
    else $error("p_wdt_sets_bits_r10");

  p_bad_keeps_state_r11: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && illegal) |-> (w == $past(w) && fl == $past(fl)))
    else $error("p_bad_keeps_state_r11");

  p_compat_gap_r12: assert property (@(posedge clk) disable iff (rst)
    (!turbo && cyc_end) |=> !cyc_end)
    else $error("p_compat_gap_r12");
endmodule

bind exu_core exu_chk u_chk (
  .clk(clk), .rst(rst), .turbo(turbo), .cyc_end(cyc_end), .skip_req(skip_req),
  .illegal(illegal), .wdt_clr(wdt_clr), .to(st_to), .pd(st_pd),
  .w(w_out), .fl({st_c, st_dc, st_z})
);

// File: tb/sim_exu_core.sv
module sim_exu_core;
  localparam int CLK_P = 10;
  localparam int NV = 25;

  // {insn, carry_ignore, w, f, c, result, to_file, {C, DC, Z, skip}}
  localparam logic [42:0] VECS [NV] = '{
    {12'h165, 1'b0, 8'h3C, 8'hF0, 1'b0, 8'h30, 1'b1, 4'b0000},
    {12'h145, 1'b0, 8'h0F, 8'hF0, 1'b1, 8'h00, 1'b0, 4'b1110},
    {12'hD81, 1'b0, 8'h10, 8'h00, 1'b0, 8'h91, 1'b0, 4'b0000},
    {12'h1A5, 1'b0, 8'h55, 8'h55, 1'b1, 8'h00, 1'b1, 4'b1110},
    {12'hFFF, 1'b0, 8'h0F, 8'h00, 1'b0, 8'hF0, 1'b0, 4'b0000},
    {12'h265, 1'b0, 8'h01, 8'hFF, 1'b1, 8'h00, 1'b1, 4'b1110},
    {12'h1E5, 1'b1, 8'h0F, 8'h01, 1'b1, 8'h10, 1'b1, 4'b0100},
    {12'h1C5, 1'b0, 8'h80, 8'h7F, 1'b1, 8'h00, 1'b0, 4'b1110},
    {12'h1E5, 1'b0, 8'h22, 8'h11, 1'b0, 8'h33, 1'b1, 4'b0000},
    {12'h0A5, 1'b1, 8'h01, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b0000},
    {12'h0A5, 1'b0, 8'h10, 8'h30, 1'b0, 8'h1F, 1'b1, 4'b1000},
    {12'h0A5, 1'b0, 8'h05, 8'h05, 1'b1, 8'h00, 1'b1, 4'b1110},
    {12'h2A5, 1'b0, 8'h01, 8'hFF, 1'b0, 8'h00, 1'b1, 4'b0010},
    {12'h0E5, 1'b0, 8'h02, 8'h01, 1'b1, 8'h00, 1'b1, 4'b1110},
    {12'h065, 1'b0, 8'h01, 8'h77, 1'b0, 8'h00, 1'b1, 4'b0010},
    {12'h365, 1'b0, 8'h01, 8'h81, 1'b0, 8'h02, 1'b1, 4'b1000},
    {12'h325, 1'b0, 8'h00, 8'h02, 1'b1, 8'h81, 1'b1, 4'b0110},
    {12'h3A5, 1'b0, 8'h00, 8'hA5, 1'b0, 8'h5A, 1'b1, 4'b0010},
    {12'h2E5, 1'b0, 8'h03, 8'h01, 1'b0, 8'h00, 1'b1, 4'b0001},
    {12'h3E5, 1'b0, 8'h00, 8'h10, 1'b1, 8'h11, 1'b1, 4'b1110},
    {12'h3E5, 1'b0, 8'h04, 8'hFF, 1'b0, 8'h00, 1'b1, 4'b0001},
    {12'h040, 1'b0, 8'h12, 8'h00, 1'b1, 8'h00, 1'b0, 4'b1110},
    {12'hE0F, 1'b0, 8'hF0, 8'h00, 1'b0, 8'h00, 1'b0, 4'b0010},
    {12'h0A5, 1'b1, 8'h03, 8'h08, 1'b0, 8'h05, 1'b1, 4'b1100},
    {12'h1E5, 1'b1, 8'hFF, 8'h01, 1'b1, 8'h00, 1'b1, 4'b1110}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        turbo = 1'b1;
  logic        ign = 1'b0;
  logic [11:0] insn = 12'h040;
  logic [7:0]  w_out, res_out;
  logic        res_to_file, st_c, st_dc, st_z, st_to, st_pd;
  logic        skip_req, illegal, wdt_clr, cyc_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exu_core u0 (
    .clk(clk), .rst(rst), .turbo(turbo), .carry_ignore(ign), .insn(insn),
    .w_out(w_out), .res_out(res_out), .res_to_file(res_to_file),
    .st_c(st_c), .st_dc(st_dc), .st_z(st_z), .st_to(st_to), .st_pd(st_pd),
    .skip_req(skip_req), .illegal(illegal), .wdt_clr(wdt_clr), .cyc_end(cyc_end)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exec(input logic [11:0] word);
    insn = word;
    do @(negedge clk); while (!cyc_end);
  endtask

  function automatic string tag(input logic [11:0] o);
    casez (o)
      12'b0001_11??_????: return "R4";
      12'b0000_101?_????: return "R5";
      12'b0011_111?_????, 12'b0010_111?_????: return "R9";
      12'b0010_101?_????, 12'b0000_111?_????, 12'b0000_011?_????, 12'b0000_0100_0000: return "R6";
      12'b0011_0?1?_????: return "R7";
      12'b0011_101?_????: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic run_vec(input logic [42:0] v);
    logic [11:0] op;
    logic [7:0]  wv, fv, val;
    logic        cv, tf, vign;
    logic [3:0]  ex;
    string       t;
    op = v[42:31]; vign = v[30]; wv = v[29:22]; fv = v[21:14];
    cv = v[13]; val = v[12:5]; tf = v[4]; ex = v[3:0];
    t = tag(op);
    exec(12'h065); exec(12'h040); exec(12'hD00 | {4'h0, fv}); exec(12'h125);
    exec(12'h040); exec(12'h07F);
    ign = 1'b1;
    exec(cv ? 12'h0BF : 12'h1FF);
    exec(12'hD00 | {4'h0, wv});
    ign = vign;
    exec(op);
    chk({t, " result"}, res_out, val);
    chk({t, " C"}, st_c, ex[3]);
    chk({t, " DC"}, st_dc, ex[2]);
    chk({t, " Z"}, st_z, ex[1]);
    chk("R2 target", res_to_file, tf);
    chk("R9 skip flag", skip_req, ex[0]);
    if (tf) chk("R2 W kept", w_out, wv);
    if (ex[0]) begin
      exec(12'h1C5);
      chk("R9 discarded W", w_out, wv);
      chk("R9 skip cleared", skip_req, 1'b0);
    end
    if (tf) begin
      exec(12'h040); exec(12'h105);
      chk("R2 file readback", w_out, val);
    end else begin
      chk("R2 W written", w_out, val);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] fl;
    int n;
    rst = 1'b1; turbo = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 W", w_out, 8'h00);
    chk("R1 flags", {3'b0, st_c, st_dc, st_z, st_to, st_pd}, 8'h00);
    chk("R1 strobes", {5'b0, skip_req, illegal, wdt_clr}, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 fast rate", cyc_end, 1'b1);
    end

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: unknown word with a literal-like pattern
    exec(12'h040); exec(12'hD5A);
    fl = {st_c, st_dc, st_z};
    exec(12'h7AB);
    chk("R11 flagged", illegal, 1'b1);
    chk("R11 W kept", w_out, 8'h5A);
    chk("R11 flags kept", {5'b0, st_c, st_dc, st_z}, {5'b0, fl});
    // R11: unknown word with a file-like pattern
    exec(12'h065); exec(12'h040); exec(12'hD33); exec(12'h125);
    exec(12'h040); exec(12'hD11);
    exec(12'h085);
    chk("R11 flagged file form", illegal, 1'b1);
    chk("R11 W kept file form", w_out, 8'h11);
    exec(12'h040);
    chk("R11 drops after one cycle", illegal, 1'b0);
    exec(12'h105);
    chk("R11 file kept", w_out, 8'h33);

    // compatible rate
    rst = 1'b1; turbo = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 time-out bit", st_to, 1'b0);
    chk("R1 power-down bit", st_pd, 1'b0);
    insn = 12'hD3C;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!cyc_end) chk("R12 no early write", w_out, 8'h00);
    end while (!cyc_end && n < 20);
    chk("R12 first slot clocks", n[7:0], 8'd4);
    chk("R12 slot result", w_out, 8'h3C);
    insn = 12'hE0F;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cyc_end && n < 20);
    chk("R12 slot spacing", n[7:0], 8'd4);
    chk("R12 second result", w_out, 8'h0C);

    exec(12'h004);
    chk("R10 time-out set", st_to, 1'b1);
    chk("R10 power-down set", st_pd, 1'b1);
    chk("R10 strobe high", wdt_clr, 1'b1);
    chk("R10 W kept", w_out, 8'h0C);
    @(negedge clk);
    chk("R10 strobe one clock", wdt_clr, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule